// File: doc/BRIEF.md
# Converter Serial Port Controller

This block is the digital half of a multi-channel converter's serial port, working with a host-supplied serial clock. Each sample goes through the same loop. The port first converts. It then sleeps with the finished result held in a 32-bit shift register. Finally it streams that frame out while taking in a 13-bit command word. The command word picks the next channel and the rate setting. A conversion stub stands in for the analog path. The stub counts a programmable number of system clocks and then hands over the sample presented on `sample_in`.

The host pins are sampled in the system clock domain. `sck_pin` and `cs_n_pin` each pass through a two-stage synchronizer, and their edges are detected from the synchronized levels. The output frame is built as follows:

- Frame bit 31 is the end-of-conversion flag, which is always 0 when a frame is read.
- Frame bit 30 is a constant 0.
- Bits 29..0 carry the 30-bit sample: the sign first, then the magnitude MSB first.

The host can end the read early by raising chip select. The new settings are applied only when enough clock edges have been seen. A word that is only partly shifted in never disturbs the active configuration.

Top module: `adc_serial_port`

## Requirements
- R1: While the synchronized chip select is high, `sdo_oe` is 0 (SDO is released to high impedance).
- R2: With chip select low and no frame in progress, `sdo` is 1 during a conversion and 0 during sleep. `busy` is 1 during conversion and 0 during sleep and during the data transfer.
- R3: A conversion lasts about `conv_len` system clocks. At its end `busy` falls and the current `sample_in` becomes the frame payload.
- R4: The first SCK rising edge in sleep starts the transfer. `sdo` advances one frame bit per SCK falling edge, so after the k-th rising edge it shows frame bit 32-k. The frame bits are: bit 31 = 0 (end-of-conversion flag), bit 30 = 0, bits 29..0 = sample.
- R5: After the 32nd SCK falling edge a new conversion starts, and both `busy` and `sdo` are 1.
- R6: SCK edges have no effect while chip select is high, and none while a conversion runs. A frame read afterwards still starts at bit 31.
- R7: If chip select rises after at least 5 SCK falling edges of a transfer, the transfer is abandoned and a conversion starts at once (`busy` = 1).
- R8: If chip select rises after fewer than 5 falling edges, nothing is abandoned: `busy` stays 0, and after chip select falls again the frame continues from the next bit.
- R9: The command word is the first 13 SDI bits, each taken on a rising edge, MSB first. Its bits are [12]=1, [11]=0, [10]=channel enable, [9]=single-ended, [8]=odd, [7:5]=address, [4:1]=rate, [0]=double-rate. The rate fields (`cfg_osr`, `cfg_twox`) are updated when a transfer ends or is abandoned, but only if all 13 bits were taken.
- R10: The channel fields (`cfg_sgl`, `cfg_odd`, `cfg_addr`) are updated only if bit [10] is 1 and at least 14 SCK falling edges occurred before the end or the abandonment.
- R11: A word whose two leading bits are not 1 then 0 updates no field.
- R12: The configuration outputs never change during a transfer, only at its end.
- R13: After reset the port is converting (`busy` = 1) and every configuration output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_pin | input | 1 | Host serial clock, idle low |
| cs_n_pin | input | 1 | Host chip select, active low |
| sdi_pin | input | 1 | Serial command input |
| conv_len | input | CNT_W | Conversion length in system clocks |
| sample_in | input | DATA_W | Sample delivered by the stub at conversion end |
| sdo | output | 1 | Serial data / status value |
| sdo_oe | output | 1 | Drive enable for SDO (0 = high impedance) |
| busy | output | 1 | Conversion in progress |
| cfg_sgl | output | 1 | Active single-ended select |
| cfg_odd | output | 1 | Active odd/polarity select |
| cfg_addr | output | 3 | Active channel address |
| cfg_osr | output | 4 | Active rate code |
| cfg_twox | output | 1 | Active double-rate flag |

## Verification
A pin change reaches the state machine after two synchronizer flops and one state register. That makes `busy`, `sdo` and the configuration valid three system clocks later, while `sdo_oe` follows chip select after two. The bench therefore holds every pin change for eight system clocks and reads the outputs on a falling system clock edge at the end of that hold. Each SCK phase is eight clocks long. The SDO bit expected after the k-th rising edge is checked while SCK is still high. `busy` and `sdo` are checked eight clocks after the final falling edge or after the chip-select rise. The end of a conversion is found by polling `busy` with a bound.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DOUT  = 2'd2
  } port_state_e;

  // command word layout (MSB first on the wire)
  localparam int unsigned CMD_BITS  = 13;
  localparam int unsigned HDR_HI    = 12;
  localparam int unsigned HDR_LO    = 11;
  localparam int unsigned EN_BIT    = 10;
  localparam int unsigned SGL_BIT   = 9;
  localparam int unsigned ODD_BIT   = 8;
  localparam int unsigned ADDR_MSB  = 7;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned OSR_MSB   = 4;
  localparam int unsigned OSR_W     = 4;
  localparam int unsigned TWOX_BIT  = 0;

  typedef struct packed {
    logic              sgl;
    logic              odd;
    logic [ADDR_W-1:0] addr;
  } chan_cfg_t;

  typedef struct packed {
    logic [OSR_W-1:0] osr;
    logic             twox;
  } rate_cfg_t;

endpackage

// File: rtl/sp_sync_edge.sv
module sp_sync_edge #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic prev
);

  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {(STAGES+1){RST_VAL}};
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign lvl  = pipe_q[STAGES-1];
  assign prev = pipe_q[STAGES];

endmodule

// File: rtl/sp_conv_stub.sv
module sp_conv_stub #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  conv_len,
  input  logic [DATA_W-1:0] sample,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  logic              active_q, active_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              expire;

  assign expire = ({1'b0, cnt_q} + 1'b1) >= {1'b0, conv_len};

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    res_d    = res_q;
    if (start) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q) begin
      if (expire) begin
        active_d = 1'b0;
        done_d   = 1'b1;
        res_d    = sample;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      res_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      done_q   <= done_d;
      res_q    <= res_d;
    end
  end

  assign done   = done_q;
  assign result = res_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/sp_frame_shift.sv
module sp_frame_shift #(
  parameter int unsigned W      = 32,
  parameter int unsigned DATA_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data,
  output logic              msb
);

  localparam int unsigned PAD = W - DATA_W;

  logic [W-1:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = sreg_q;
    if (load) begin
      sreg_d = {{PAD{1'b0}}, data};
    end else if (shift) begin
      sreg_d = {sreg_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else begin
      sreg_q <= sreg_d;
    end
  end

  assign msb = sreg_q[W-1];

  // R4
  frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (msb == 1'b0));

endmodule

// File: rtl/sp_cfg_capture.sv
module sp_cfg_capture
  import adc_sp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      take,
  input  logic      bit_in,
  input  logic      commit,
  input  logic      chan_ok,
  output chan_cfg_t chan_o,
  output rate_cfg_t rate_o
);

  localparam int unsigned NB_W = $clog2(CMD_BITS + 1);
  localparam logic [NB_W-1:0] NB_FULL = NB_W'(CMD_BITS);

  logic [CMD_BITS-1:0] word_q, word_d;
  logic [NB_W-1:0]     nbits_q, nbits_d;
  chan_cfg_t           chan_q, chan_d;
  rate_cfg_t           rate_q, rate_d;
  logic                full, header_ok, en;

  assign full      = (nbits_q == NB_FULL);
  assign header_ok = (word_q[HDR_HI] == 1'b1) && (word_q[HDR_LO] == 1'b0);
  assign en        = word_q[EN_BIT];

  always_comb begin
    word_d  = word_q;
    nbits_d = nbits_q;
    chan_d  = chan_q;
    rate_d  = rate_q;
    if (clear) begin
      word_d  = '0;
      nbits_d = '0;
    end else if (take && !full) begin
      word_d  = {word_q[CMD_BITS-2:0], bit_in};
      nbits_d = nbits_q + 1'b1;
    end
    if (commit && full && header_ok) begin
      rate_d.osr  = word_q[OSR_MSB -: OSR_W];
      rate_d.twox = word_q[TWOX_BIT];
      if (chan_ok && en) begin
        chan_d.sgl  = word_q[SGL_BIT];
        chan_d.odd  = word_q[ODD_BIT];
        chan_d.addr = word_q[ADDR_MSB -: ADDR_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      nbits_q <= '0;
      chan_q  <= '0;
      rate_q  <= '0;
    end else begin
      word_q  <= word_d;
      nbits_q <= nbits_d;
      chan_q  <= chan_d;
      rate_q  <= rate_d;
    end
  end

  assign chan_o = chan_q;
  assign rate_o = rate_q;

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(chan_q) && $stable(rate_q)));

  // R11
  hdr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !header_ok) |=> ($stable(chan_q) && $stable(rate_q)));

  // R10
  chan_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !chan_ok) |=> $stable(chan_q));

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int unsigned FRAME_BITS      = 32,
  parameter int unsigned DATA_W          = 30,
  parameter int unsigned CNT_W           = 16,
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned ABORT_MIN_FALLS = 5,
  parameter int unsigned CHAN_MIN_FALLS  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_pin,
  input  logic              cs_n_pin,
  input  logic              sdi_pin,
  input  logic [CNT_W-1:0]  conv_len,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy,
  output logic              cfg_sgl,
  output logic              cfg_odd,
  output logic [2:0]        cfg_addr,
  output logic [3:0]        cfg_osr,
  output logic              cfg_twox
);

  localparam int unsigned FC_W = $clog2(FRAME_BITS);
  localparam logic [FC_W-1:0] FC_LAST  = FC_W'(FRAME_BITS - 1);
  localparam logic [FC_W-1:0] FC_ABORT = FC_W'(ABORT_MIN_FALLS);
  localparam logic [FC_W-1:0] FC_CHAN  = FC_W'(CHAN_MIN_FALLS);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_ns = rst_pipe_q[1];

  logic sck_lvl, sck_prev, cs_lvl, cs_prev, sdi_lvl, sdi_prev;

  sp_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_ns), .d(sck_pin), .lvl(sck_lvl), .prev(sck_prev));
  sp_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_ns), .d(cs_n_pin), .lvl(cs_lvl), .prev(cs_prev));
  sp_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi_sync (
    .clk(clk), .rst_n(rst_ns), .d(sdi_pin), .lvl(sdi_lvl), .prev(sdi_prev));

  logic sck_rise_g, sck_fall_g, cs_rise;

  assign sck_rise_g = sck_lvl & ~sck_prev & ~cs_lvl;
  assign sck_fall_g = ~sck_lvl & sck_prev & ~cs_lvl;
  assign cs_rise    = cs_lvl & ~cs_prev;

  port_state_e       state_q, state_d;
  logic [FC_W-1:0]   fcnt_q, fcnt_d;
  logic              load, shift, take, start, commit, chan_ok;
  logic              conv_done, frame_msb;
  logic [DATA_W-1:0] conv_result;
  chan_cfg_t         chan_cfg;
  rate_cfg_t         rate_cfg;

  always_comb begin
    state_d = state_q;
    fcnt_d  = fcnt_q;
    load    = 1'b0;
    shift   = 1'b0;
    take    = 1'b0;
    start   = 1'b0;
    commit  = 1'b0;
    case (state_q)
      ST_CONV: begin
        if (conv_done) begin
          state_d = ST_SLEEP;
          load    = 1'b1;
          fcnt_d  = '0;
        end
      end
      ST_SLEEP: begin
        if (sck_rise_g) begin
          state_d = ST_DOUT;
          take    = 1'b1;
        end
      end
      ST_DOUT: begin
        if (cs_rise && (fcnt_q >= FC_ABORT)) begin
          state_d = ST_CONV;
          start   = 1'b1;
          commit  = 1'b1;
        end else begin
          take = sck_rise_g;
          if (sck_fall_g) begin
            shift = 1'b1;
            if (fcnt_q == FC_LAST) begin
              state_d = ST_CONV;
              start   = 1'b1;
              commit  = 1'b1;
              fcnt_d  = '0;
            end else begin
              fcnt_d = fcnt_q + 1'b1;
            end
          end
        end
      end
      default: begin
        state_d = ST_CONV;
        start   = 1'b1;
      end
    endcase
  end

  assign chan_ok = (fcnt_q >= FC_CHAN);

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_CONV;
      fcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      fcnt_q  <= fcnt_d;
    end
  end

  sp_conv_stub #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_stub (
    .clk(clk), .rst_n(rst_ns), .start(start), .conv_len(conv_len),
    .sample(sample_in), .done(conv_done), .result(conv_result));

  sp_frame_shift #(.W(FRAME_BITS), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_ns), .load(load), .shift(shift),
    .data(conv_result), .msb(frame_msb));

  sp_cfg_capture u_cfg (
    .clk(clk), .rst_n(rst_ns), .clear(load), .take(take), .bit_in(sdi_lvl),
    .commit(commit), .chan_ok(chan_ok), .chan_o(chan_cfg), .rate_o(rate_cfg));

  assign busy     = (state_q == ST_CONV);
  assign sdo      = busy ? 1'b1 : frame_msb;
  assign sdo_oe   = ~cs_lvl;
  assign cfg_sgl  = chan_cfg.sgl;
  assign cfg_odd  = chan_cfg.odd;
  assign cfg_addr = chan_cfg.addr;
  assign cfg_osr  = rate_cfg.osr;
  assign cfg_twox = rate_cfg.twox;

  logic unused_sdi;
  assign unused_sdi = sdi_prev;

  // R7
  abort_restart_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_DOUT && cs_rise && fcnt_q >= FC_ABORT) |=> (busy && sdo));

  // R5
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_DOUT && !cs_rise && sck_fall_g && fcnt_q == FC_LAST) |=> (busy && sdo));

  // R6
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_SLEEP && !sck_rise_g) |=> ($stable(frame_msb) && !busy));

  // R8
  early_cs_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_DOUT && cs_rise && fcnt_q < FC_ABORT) |=> !busy);

endmodule

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;

  logic        clk;
  logic        rst_n;
  logic        sck_pin, cs_n_pin, sdi_pin;
  logic [15:0] conv_len;
  logic [29:0] sample_in;
  logic        sdo, sdo_oe, busy;
  logic        cfg_sgl, cfg_odd, cfg_twox;
  logic [2:0]  cfg_addr;
  logic [3:0]  cfg_osr;

  int checks;
  int errors;
  logic [4:0] m_chan;
  logic [4:0] m_rate;

  adc_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .sck_pin(sck_pin), .cs_n_pin(cs_n_pin),
    .sdi_pin(sdi_pin), .conv_len(conv_len), .sample_in(sample_in),
    .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .cfg_sgl(cfg_sgl),
    .cfg_odd(cfg_odd), .cfg_addr(cfg_addr), .cfg_osr(cfg_osr),
    .cfg_twox(cfg_twox));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [12:0] make_cmd(input logic [1:0] hdr, input logic en,
                                            input logic [4:0] ch, input logic [4:0] rt);
    return {hdr, en, ch, rt};
  endfunction

  task automatic model_commit(input logic [12:0] cmd, input int rises, input int falls);
    if (rises >= 13 && cmd[12:11] == 2'b10) begin
      m_rate = cmd[4:0];
      if (falls >= 14 && cmd[10]) m_chan = cmd[9:5];
    end
  endtask

  task automatic check_cfg(input string req);
    chk({cfg_sgl, cfg_odd, cfg_addr} == m_chan, {req, " channel"},
        {27'd0, cfg_sgl, cfg_odd, cfg_addr}, {27'd0, m_chan});
    chk({cfg_osr, cfg_twox} == m_rate, {req, " rate"},
        {27'd0, cfg_osr, cfg_twox}, {27'd0, m_rate});
  endtask

  function automatic logic cmd_bit(input logic [12:0] cmd, input int k);
    logic [31:0] r;
    r = $urandom;
    return (k <= 13) ? cmd[13-k] : r[0];
  endfunction

  task automatic pulse(input logic b, input logic [31:0] frm, input int k);
    sdi_pin = b;
    sck_pin = 1'b1;
    wclk(8);
    // R4: bit 32-k visible after the k-th rising edge
    chk(sdo_oe && sdo === frm[32-k], "R4 frame bit", {31'd0, sdo}, {31'd0, frm[32-k]});
    sck_pin = 1'b0;
    wclk(8);
  endtask

  task automatic do_frame(input logic [29:0] s, input logic [12:0] cmd,
                          input int n, input bit noise);
    logic [31:0] frm;
    int t;
    frm = {2'b00, s};
    sample_in = s;
    cs_n_pin = 1'b0;
    wclk(8);
    // R2: converting
    chk(busy && sdo && sdo_oe, "R2 converting status", {29'd0, busy, sdo, sdo_oe}, 32'd7);
    if (noise) begin
      for (int i = 0; i < 2; i++) begin
        sck_pin = 1'b1; wclk(8); sck_pin = 1'b0; wclk(8);
      end
    end
    t = 0;
    while (busy && t < 1000) begin
      wclk(1);
      t++;
    end
    // R3
    chk(!busy, "R3 conversion end", {31'd0, busy}, 32'd0);
    wclk(4);
    // R2: sleeping
    chk(sdo == 1'b0 && !busy, "R2 sleep status", {30'd0, busy, sdo}, 32'd0);
    if (noise) begin
      cs_n_pin = 1'b1;
      wclk(8);
      for (int i = 0; i < 2; i++) begin
        sck_pin = 1'b1; wclk(8); sck_pin = 1'b0; wclk(8);
      end
      cs_n_pin = 1'b0;
      wclk(8);
      // R6: edges with CS high or during conversion left the port asleep
      chk(sdo == 1'b0 && !busy, "R6 ignored edges", {30'd0, busy, sdo}, 32'd0);
    end
    for (int k = 1; k <= n; k++) begin
      pulse(cmd_bit(cmd, k), frm, k);
      if (k == 12) check_cfg("R12 mid-word");
    end
    if (n == 32) begin
      // R5
      chk(busy && sdo, "R5 restart after frame", {30'd0, busy, sdo}, 32'd3);
      cs_n_pin = 1'b1;
      wclk(8);
      // R1
      chk(!sdo_oe, "R1 released", {31'd0, sdo_oe}, 32'd0);
      model_commit(cmd, 32, 32);
    end else begin
      cs_n_pin = 1'b1;
      wclk(8);
      chk(!sdo_oe, "R1 released", {31'd0, sdo_oe}, 32'd0);
      if (n >= 5) begin
        // R7
        chk(busy == 1'b1, "R7 abort restarts", {31'd0, busy}, 32'd1);
        model_commit(cmd, n, n);
      end else begin
        // R8
        chk(busy == 1'b0, "R8 early CS ignored", {31'd0, busy}, 32'd0);
        cs_n_pin = 1'b0;
        wclk(8);
        for (int k = n + 1; k <= 32; k++) pulse(cmd_bit(cmd, k), frm, k);
        chk(busy && sdo, "R5 restart after resumed frame", {30'd0, busy, sdo}, 32'd3);
        cs_n_pin = 1'b1;
        wclk(8);
        model_commit(cmd, 32, 32);
      end
    end
    // R9 R10 R11
    check_cfg("R9 R10 R11 commit");
  endtask

  initial begin
    wclk(150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [29:0] s;
    logic [12:0] cmd;
    int n;
    checks = 0;
    errors = 0;
    m_chan = '0;
    m_rate = '0;
    r = $urandom(32'd1234);
    rst_n = 1'b0;
    sck_pin = 1'b0;
    cs_n_pin = 1'b1;
    sdi_pin = 1'b0;
    conv_len = 16'd120;
    sample_in = '0;
    wclk(5);
    rst_n = 1'b1;
    wclk(6);
    // R13
    chk(busy && !sdo_oe, "R13 reset state", {30'd0, busy, sdo_oe}, 32'd2);
    check_cfg("R13 reset config");

    // directed corners
    do_frame(30'h2ABCDEF1, make_cmd(2'b10, 1'b1, 5'b10110, 5'b01011), 32, 1'b0);
    do_frame(30'h15555555, make_cmd(2'b10, 1'b1, 5'b01001, 5'b11100), 12, 1'b0);
    do_frame(30'h3FFFFFFF, make_cmd(2'b10, 1'b1, 5'b00111, 5'b10001), 13, 1'b0);
    do_frame(30'h00000001, make_cmd(2'b10, 1'b1, 5'b11010, 5'b00110), 14, 1'b0);
    do_frame(30'h20000000, make_cmd(2'b11, 1'b1, 5'b00001, 5'b11111), 32, 1'b0);
    do_frame(30'h0F0F0F0F, make_cmd(2'b10, 1'b1, 5'b10101, 5'b01110), 3, 1'b0);
    do_frame(30'h12345678, make_cmd(2'b10, 1'b0, 5'b01100, 5'b10011), 32, 1'b0);
    do_frame(30'h0A5A5A5A, make_cmd(2'b10, 1'b1, 5'b00010, 5'b00101), 32, 1'b1);

    // constrained random
    for (int i = 0; i < 10; i++) begin
      r = $urandom;
      s = r[29:0];
      r = $urandom;
      cmd = make_cmd((r[3:0] == 4'd0) ? 2'b01 : 2'b10, r[4], r[9:5], r[14:10]);
      r = $urandom;
      case (r[1:0])
        2'd0:    n = 32;
        2'd1:    n = 1 + int'(r[7:2] % 6'd4);
        default: n = 5 + int'(r[12:2] % 11'd27);
      endcase
      do_frame(s, cmd, n, r[13]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule